// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract and Compare Unit

This block treats two 64-bit operands as packed integer lanes and applies one operation to all lanes at once. A lane-size input splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. A 3-bit operation code picks one of eight operations: add or subtract that wraps, add or subtract that saturates as signed values, add or subtract that saturates as unsigned values, an equality compare, or a signed greater-than compare.

The unit is one pipeline stage in an execution path. An operand pair that arrives with `in_valid` high produces a registered result one clock later, and `out_valid` marks that result. No condition flags are produced. A compare writes its outcome into the result lanes as masks, so later logic operations can use the result to select between values without branching.

A single chain of byte adders, broken at lane starts, serves every operation. Compares reuse the subtract path. Per-lane post-processing, built for each lane size, applies the clamping or mask generation.

Top module: `simd_packed_alu`

## Requirements
- R1: `lane_size` sets the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, and 2'b10 or 2'b11 give 32-bit lanes. Lane k covers bits [k*W+W-1 : k*W]. No carry or borrow ever crosses from one lane into the next.
- R2: Op 3'b000 is a wrap-around add and op 3'b001 is a wrap-around subtract (A minus B). Each lane gives its result modulo 2^W.
- R3: Op 3'b010 is a signed-saturating add and op 3'b011 is a signed-saturating subtract (A minus B). A lane result above 2^(W-1)-1 becomes 2^(W-1)-1, and a result below -2^(W-1) becomes -2^(W-1).
- R4: Op 3'b100 is an unsigned-saturating add and op 3'b101 is an unsigned-saturating subtract (A minus B). A lane result above 2^W-1 becomes 2^W-1, and a negative result becomes 0.
- R5: Op 3'b110 is an equality compare. A lane is all ones where the A and B lanes are equal, and all zeros otherwise.
- R6: Op 3'b111 is a signed greater-than compare. A lane is all ones where the A lane is greater than the B lane as two's-complement numbers, and all zeros otherwise. Equal lanes give zeros.
- R7: `result` and `out_valid` update on the clock edge that samples `in_valid` high. `out_valid` is low one edge after a cycle in which `in_valid` is low.
- R8: While `in_valid` is low, the operand, op and lane-size inputs have no effect, and `result` keeps its last value.
- R9: `rst_n` is a synchronous, active-low reset. It clears `result` to zero and `out_valid` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 3 | Operation code |
| lane_size | input | 2 | Lane width select |
| src_a | input | 64 | Operand A (minuend for subtract and compare) |
| src_b | input | 64 | Operand B |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered lane-wise result |

## Verification
The unit has only one register stage, so any wrong internal value appears at `result` on the edge right after the operand pair that caused it. A carry chain that is broken in the wrong place shows up as a corrupted neighbouring lane for the affected lane size. A wrong overflow or borrow decision shows up as a missing or spurious clamp, or as a mask with the wrong polarity. The bench keeps an independent lane-by-lane model and compares both outputs on every cycle. Operands are weighted toward the limit values 0x00, 0x7F, 0x80 and 0xFF, so clamp and compare edges are reached in every lane width.

// File: rtl/simd_pkg.sv
// Shared types for the packed SIMD add/subtract/compare unit.
// Assumes byte-granular lanes: every lane width is a power-of-two multiple
// of BYTE_W.
package simd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_ADDSS = 3'd2,
        OP_SUBSS = 3'd3,
        OP_ADDUS = 3'd4,
        OP_SUBUS = 3'd5,
        OP_CMPEQ = 3'd6,
        OP_CMPGT = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        LANE_8   = 2'd0,
        LANE_16  = 2'd1,
        LANE_32  = 2'd2,
        LANE_32X = 2'd3
    } lane_size_e;

    // True for every operation that feeds A minus B into the adder.
    function automatic logic op_uses_sub(simd_op_e o);
        return (o == OP_SUB) || (o == OP_SUBSS) || (o == OP_SUBUS) ||
               (o == OP_CMPEQ) || (o == OP_CMPGT);
    endfunction

    // Maps the lane-size code onto log2 of the lane width in bytes.
    function automatic int unsigned lane_shift(lane_size_e s);
        case (s)
            LANE_8:  return 0;
            LANE_16: return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/simd_byte_adder.sv
// Byte-sliced adder that is shared by every operation.
// Each byte slice adds A to B, or to the complement of B when sub is set.
// A byte whose lane_start bit is set takes its carry-in from sub (0 for add,
// 1 for the two's-complement subtract), which cuts the chain at lane edges.
// Every byte's carry-out is exported so the lane logic can detect
// unsigned overflow or borrow.
module simd_byte_adder #(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8,
    localparam int NB    = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [NB-1:0]     lane_start,
    output logic [DATA_W-1:0] sum,
    output logic [NB-1:0]     byte_cout
);

    logic              carry;
    logic              cin;
    logic [BYTE_W-1:0] b_eff;
    logic [BYTE_W:0]   part;

    // Ripple the byte slices, restarting the carry at every lane start.
    always_comb begin
        carry     = 1'b0;
        cin       = 1'b0;
        b_eff     = '0;
        part      = '0;
        sum       = '0;
        byte_cout = '0;
        for (int i = 0; i < NB; i++) begin
            cin   = lane_start[i] ? sub : carry;
            b_eff = sub ? ~b[i*BYTE_W +: BYTE_W] : b[i*BYTE_W +: BYTE_W];
            part  = {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, b_eff}
                  + {{BYTE_W{1'b0}}, cin};
            sum[i*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
            byte_cout[i]            = part[BYTE_W];
            carry                   = part[BYTE_W];
        end
    end

endmodule

// File: rtl/simd_lane_post.sv
// Per-lane result formation for one fixed lane width LANE_W.
// Uses the shared byte-adder sum, which must have been built with lane
// starts that match LANE_W. Per lane it applies the wrap, signed clamp,
// unsigned clamp, equality mask or signed greater-than mask.
// Assumes that compares were run through the subtract path (A minus B).
module simd_lane_post
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8,
    parameter int LANE_W = 8,
    localparam int NB    = DATA_W / BYTE_W,
    localparam int NL    = DATA_W / LANE_W
) (
    input  simd_op_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] sum,
    input  logic [NB-1:0]     byte_cout,
    output logic [DATA_W-1:0] result
);

    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] ONES  = {LANE_W{1'b1}};

    logic sub;

    // Decide whether the adder saw A plus B or A minus B.
    always_comb sub = op_uses_sub(op);

    for (genvar j = 0; j < NL; j++) begin : g_lane
        localparam int LO = j * LANE_W;
        localparam int HI = LO + LANE_W - 1;
        localparam int TB = (LO + LANE_W) / BYTE_W - 1;

        logic              a_msb, b_msb, s_msb;
        logic              s_ovf, c_out, is_zero;
        logic [LANE_W-1:0] s_lane, r_lane;

        // Gather the sign bits, overflow and carry of this lane.
        always_comb begin
            s_lane  = sum[LO +: LANE_W];
            a_msb   = a[HI];
            b_msb   = sub ? ~b[HI] : b[HI];
            s_msb   = sum[HI];
            s_ovf   = (a_msb == b_msb) && (s_msb != a_msb);
            c_out   = byte_cout[TB];
            is_zero = (s_lane == '0);
        end

        // Choose the lane result for the active operation.
        always_comb begin
            case (op)
                OP_ADDSS, OP_SUBSS: r_lane = s_ovf ? (a_msb ? S_MIN : S_MAX) : s_lane;
                OP_ADDUS:           r_lane = c_out ? ONES : s_lane;
                OP_SUBUS:           r_lane = c_out ? s_lane : '0;
                OP_CMPEQ:           r_lane = is_zero ? ONES : '0;
                OP_CMPGT:           r_lane = (!(s_msb ^ s_ovf) && !is_zero) ? ONES : '0;
                default:            r_lane = s_lane;
            endcase
        end

        assign result[LO +: LANE_W] = r_lane;
    end

endmodule

// File: rtl/simd_packed_alu.sv
// Top of the packed SIMD add/subtract/compare unit.
// Builds the lane-start mask from lane_size, runs the shared byte adder,
// forms candidate results for the 8, 16 and 32-bit lane widths, and
// registers the chosen one together with a valid bit.
// Assumes DATA_W is a multiple of four bytes. Reset is synchronous and
// active low.
module simd_packed_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [1:0]        lane_size,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    localparam int NB     = DATA_W / BYTE_W;
    localparam int NSIZES = 3;

    simd_op_e          op_e;
    lane_size_e        size_e;
    logic [NB-1:0]     lane_start;
    logic [DATA_W-1:0] sum;
    logic [NB-1:0]     byte_cout;
    logic [DATA_W-1:0] cand [NSIZES];
    logic [DATA_W-1:0] next_result;

    assign op_e   = simd_op_e'(op);
    assign size_e = lane_size_e'(lane_size);

    // Flag each byte that opens a new lane for the selected width.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            lane_start[i] = ((i % (1 << lane_shift(size_e))) == 0);
        end
    end

    simd_byte_adder #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) i_adder (
        .a          (src_a),
        .b          (src_b),
        .sub        (op_uses_sub(op_e)),
        .lane_start (lane_start),
        .sum        (sum),
        .byte_cout  (byte_cout)
    );

    for (genvar k = 0; k < NSIZES; k++) begin : g_size
        simd_lane_post #(
            .DATA_W (DATA_W),
            .BYTE_W (BYTE_W),
            .LANE_W (BYTE_W << k)
        ) i_post (
            .op        (op_e),
            .a         (src_a),
            .b         (src_b),
            .sum       (sum),
            .byte_cout (byte_cout),
            .result    (cand[k])
        );
    end

    // Pick the candidate that matches the requested lane width.
    always_comb next_result = cand[lane_shift(size_e)];

    // Register the result when a new operand pair arrives; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_result;
        end
    end

    // True when every byte of x is either all zeros or all ones.
    function automatic logic bytes_are_masks(logic [DATA_W-1:0] x);
        logic ok = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (x[i*BYTE_W +: BYTE_W] != '0 && x[i*BYTE_W +: BYTE_W] != '1) ok = 1'b0;
        end
        return ok;
    endfunction

    // True when every byte of x is no smaller than the same byte of y.
    function automatic logic bytes_not_below(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
        logic ok = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (x[i*BYTE_W +: BYTE_W] < y[i*BYTE_W +: BYTE_W]) ok = 1'b0;
        end
        return ok;
    endfunction

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R5
    eq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_CMPEQ) |=> bytes_are_masks(result));

    // R6
    gt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_CMPGT) |=> bytes_are_masks(result));

    // R4
    usat_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_ADDUS && size_e == LANE_8)
            |=> bytes_not_below(result, $past(src_a)));

endmodule

// File: tb/test_simd_packed_alu.sv
`timescale 1ns/1ps
module test_simd_packed_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  lane_size = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_res = '0;
    logic        exp_val = 1'b0;
    bit          have_exp = 1'b0;
    string       res_tag = "R9";
    string       val_tag = "R9";

    always #10 clk = ~clk;

    simd_packed_alu i_simd_packed_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .lane_size (lane_size),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    // Behavioural lane model built from the requirement text.
    function automatic logic [63:0] model(int o, int sz, logic [63:0] a, logic [63:0] b);
        int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        longint mask = (longint'(1) <<< w) - 1;
        longint half = longint'(1) <<< (w - 1);
        logic [63:0] res = '0;
        for (int l = 0; l < 64 / w; l++) begin
            longint ua = longint'((a >> (l * w)) & 64'(mask));
            longint ub = longint'((b >> (l * w)) & 64'(mask));
            longint sa = (ua >= half) ? ua - (mask + 1) : ua;
            longint sb = (ub >= half) ? ub - (mask + 1) : ub;
            longint r;
            case (o)
                0: r = ua + ub;
                1: r = ua - ub;
                2: r = sa + sb;
                3: r = sa - sb;
                4: r = ua + ub;
                5: r = ua - ub;
                6: r = (ua == ub) ? mask : 0;
                default: r = (sa > sb) ? mask : 0;
            endcase
            if (o == 2 || o == 3) begin
                if (r > half - 1) r = half - 1;
                if (r < -half) r = -half;
            end
            if (o == 4 || o == 5) begin
                if (r > mask) r = mask;
                if (r < 0) r = 0;
            end
            res = res | (64'(r & mask) << (l * w));
        end
        return res;
    endfunction

    function automatic string op_tag(int o);
        case (o)
            0, 1: return "R2";
            2, 3: return "R3";
            4, 5: return "R4";
            6:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Check the outputs of the last edge, then drive the next cycle's inputs.
    task automatic cycle(logic r_n, logic v, int o, int sz,
                         logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        if (have_exp) begin
            check(val_tag, {63'd0, out_valid}, {63'd0, exp_val});
            check(res_tag, result, exp_res);
        end
        rst_n = r_n; in_valid = v; op = 3'(o); lane_size = 2'(sz);
        src_a = a; src_b = b;
        have_exp = 1'b1;
        if (!r_n) begin
            exp_val = 1'b0; exp_res = '0; val_tag = "R9";
        end else begin
            exp_val = v; val_tag = "R7";
            if (v) exp_res = model(o, sz, a, b);
        end
        if (tag != "") res_tag = tag;
        else if (!r_n) res_tag = "R9";
        else if (v) res_tag = op_tag(o);
        else res_tag = "R8";
    endtask

    function automatic logic [63:0] pick_operand();
        logic [63:0] x;
        if ($urandom_range(1, 0) == 0) return {$urandom, $urandom};
        for (int i = 0; i < 8; i++) begin
            case ($urandom_range(7, 0))
                0: x[i*8 +: 8] = 8'h00;
                1: x[i*8 +: 8] = 8'h01;
                2: x[i*8 +: 8] = 8'h7F;
                3: x[i*8 +: 8] = 8'h80;
                4: x[i*8 +: 8] = 8'hFF;
                5: x[i*8 +: 8] = 8'h7E;
                6: x[i*8 +: 8] = 8'h81;
                default: x[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return x;
    endfunction

    initial begin
        // R9: reset state
        cycle(0, 0, 0, 0, '0, '0, "R9");
        cycle(0, 1, 0, 0, 64'h1, 64'h1, "R9");
        // R1: carries stop at lane edges in each width
        cycle(1, 1, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0101_0101_0101_0101, "R1");
        cycle(1, 1, 1, 1, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, "R1");
        cycle(1, 1, 0, 2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R1");
        cycle(1, 1, 0, 3, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R1");
        // R2: wrap
        cycle(1, 1, 0, 1, 64'hFFFF_7FFF_0001_8000, 64'h0001_0001_FFFF_8000, "R2");
        // R3: signed clamp at both limits
        cycle(1, 1, 2, 0, 64'h7F7F_8080_0102_7F80, 64'h0101_FFFF_0203_8080, "R3");
        cycle(1, 1, 3, 2, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, "R3");
        // R4: unsigned clamp at both limits
        cycle(1, 1, 4, 1, 64'hFFFF_8000_0001_1234, 64'h0001_8000_0001_0000, "R4");
        cycle(1, 1, 5, 0, 64'h0010_FF05_0000_8001, 64'h0111_FF06_0100_8000, "R4");
        // R5 and R6: masks, equality and signed ordering
        cycle(1, 1, 6, 0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R5");
        cycle(1, 1, 7, 0, 64'h7F80_0001_FF00_0505, 64'h8080_FF00_0000_0504, "R6");
        cycle(1, 1, 7, 1, 64'h8000_7FFF_0000_1234, 64'h7FFF_8000_0000_1234, "R6");
        // R8: idle cycles with moving inputs leave the result alone
        for (int i = 0; i < 6; i++)
            cycle(1, 0, i % 8, i % 4, {$urandom, $urandom}, {$urandom, $urandom}, "R8");
        // Mixed random traffic
        for (int i = 0; i < 3000; i++)
            cycle(1, ($urandom_range(7, 0) != 0), $urandom_range(7, 0), $urandom_range(3, 0),
                  pick_operand(), pick_operand(), "");
        // R9: reset mid-stream with a valid operand present
        cycle(0, 1, 0, 0, 64'hFF, 64'h1, "R9");
        cycle(1, 1, 0, 0, 64'h1, 64'h1, "");
        cycle(1, 0, 0, 0, '0, '0, "");
        cycle(1, 0, 0, 0, '0, '0, "");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R7: watchdog expired, got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule